// File: doc/BRIEF.md
# Clock validity and PPS supervisor

This block decides whether a disciplined local clock can still be trusted, and it keeps a record of a one-pulse-per-second timing input. It holds an age counter that grows on every periodic adjustment strobe and is cleared whenever a fresh synchronization update arrives. If no update comes for one full day of adjustment intervals, the age counter saturates and the leap-indicator output is forced to the "unsynchronized" code. The leap indicator otherwise carries the code supplied with the latest synchronization update.

In parallel, a small signed presence counter is re-armed on every seconds pulse and decays by the adjustment step on each strobe for as long as it is positive. The pulse-valid output shows whether that counter is still above zero. Each seconds pulse also latches the measured time offset, given in milliseconds, into a signed adjust register. Before it is stored, the offset is folded to the nearest second: any value of 500 or more has 1000 taken off it. The offset measurement and the loop filter that uses these values sit outside the block.

All outputs come straight from flip-flops and change one clock after the input that caused them.

Top module: `sync_supervisor`

## Requirements
- R1: A synchronous reset sets the leap output to 2'b11 (unsynchronized), clears the pulse-valid output and clears the adjust output.
- R2: A seconds pulse loads the presence counter with PPS_RELOAD. From the next cycle the pulse-valid output is high and the adjust output holds the folded offset.
- R3: On a seconds pulse the stored value is the offset minus FOLD_SPAN (1000) when the offset is at least FOLD_AT (500), compared as signed. Otherwise the offset is stored unchanged, and this includes negative offsets.
- R4: An adjustment strobe subtracts PPS_STEP from the presence counter only when the counter's previous value is greater than zero. The pulse-valid output is high exactly when the counter is greater than zero.
- R5: Once the presence counter is zero or negative, further strobes leave it unchanged, so the pulse-valid output stays low however many strobes follow.
- R6: Each adjustment strobe adds AGE_STEP to the age counter, and the counter is clamped at AGE_LIMIT. The strobe that brings the counter to AGE_LIMIT forces the leap output to 2'b11, and it stays there until the next synchronization update.
- R7: A synchronization update clears the age counter and loads the leap output from the supplied code. When it coincides with a strobe, the update wins and the age counter ends at zero.
- R8: When a seconds pulse and a strobe arrive in the same cycle, the presence counter takes the reload value and is not decremented.
- R9: Between seconds pulses the adjust output holds its value, whatever the offset input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_tick | input | 1 | Adjustment-interval strobe, one cycle wide |
| pps_pulse | input | 1 | Seconds pulse event, one cycle wide |
| pps_offset | input | OFS_W | Signed measured offset in milliseconds, sampled with pps_pulse |
| sync_upd | input | 1 | Synchronization update strobe |
| sync_leap | input | 2 | Leap code loaded by sync_upd (2'b11 = unsynchronized) |
| leap_o | output | 2 | Current leap indicator |
| pps_valid_o | output | 1 | High while the presence counter is positive |
| pps_adj_o | output | OFS_W | Signed, folded seconds-pulse adjustment |

## Verification
The bench uses a short day of 42 with a step of 4. The clamp is therefore reached by an addition that overshoots the limit. A design that compared for equality with the limit, or that let the count wrap, would never raise the unsynchronized code. The fold is driven at 499, 500, 999, 1000 and at negative offsets, which exposes an off-by-one threshold or an unsigned compare. The presence counter is strobed forty more times after it turns negative; a decrement that ignored the sign would wrap it back to a positive value and bring the valid flag back. Coincident pulse and strobe, and coincident update and strobe, are each timed so that a reversed priority shifts the cycle at which pulse-valid drops or the leap code turns to 2'b11.

// File: rtl/sync_sup_pkg.sv
package sync_sup_pkg;
  typedef enum logic [1:0] {
    LEAP_NONE   = 2'b00,
    LEAP_ADD    = 2'b01,
    LEAP_DEL    = 2'b10,
    LEAP_UNSYNC = 2'b11
  } leap_e;
endpackage

// File: rtl/age_watchdog.sv
module age_watchdog
  import sync_sup_pkg::*;
#(
  parameter int AGE_W     = 16,
  parameter int AGE_STEP  = 4,
  parameter int AGE_LIMIT = 21600
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  sync_upd,
  input  leap_e sync_leap,
  output leap_e leap_q
);
  localparam int SUM_W = AGE_W + 1;
  localparam logic [SUM_W-1:0] STEP_V  = SUM_W'(AGE_STEP);
  localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(AGE_LIMIT);

  logic [AGE_W-1:0] age_q;
  logic [SUM_W-1:0] age_sum;
  logic             at_limit;

  // widened add so an overshoot past the limit is seen before it can wrap
  assign age_sum  = {1'b0, age_q} + STEP_V;
  assign at_limit = (age_sum >= LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= '0;
      leap_q <= LEAP_UNSYNC;
    end else if (sync_upd) begin
      age_q  <= '0;
      leap_q <= sync_leap;
    end else if (tick) begin
      if (at_limit) begin
        age_q  <= LIMIT_V[AGE_W-1:0];
        leap_q <= LEAP_UNSYNC;
      end else begin
        age_q  <= age_sum[AGE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pps_presence.sv
module pps_presence #(
  parameter int CNT_W      = 8,
  parameter int PPS_STEP   = 4,
  parameter int PPS_RELOAD = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pulse,
  output logic valid_q
);
  localparam logic signed [CNT_W-1:0] STEP_V   = CNT_W'(PPS_STEP);
  localparam logic signed [CNT_W-1:0] RELOAD_V = CNT_W'(PPS_RELOAD);
  localparam logic signed [CNT_W-1:0] ZERO_V   = '0;

  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next = cnt_q;
    if (pulse) begin
      cnt_next = RELOAD_V;
    end else if (tick && (cnt_q > ZERO_V)) begin
      cnt_next = cnt_q - STEP_V;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO_V;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_next;
      valid_q <= (cnt_next > ZERO_V);
    end
  end
endmodule

// File: rtl/offset_folder.sv
module offset_folder #(
  parameter int OFS_W     = 32,
  parameter int FOLD_AT   = 500,
  parameter int FOLD_SPAN = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [OFS_W-1:0] ofs_in,
  output logic signed [OFS_W-1:0] adj_q
);
  localparam logic signed [OFS_W-1:0] AT_V   = OFS_W'(FOLD_AT);
  localparam logic signed [OFS_W-1:0] SPAN_V = OFS_W'(FOLD_SPAN);

  logic signed [OFS_W-1:0] folded;

  assign folded = (ofs_in >= AT_V) ? (ofs_in - SPAN_V) : ofs_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_q <= '0;
    end else if (load) begin
      adj_q <= folded;
    end
  end
endmodule

// File: rtl/sync_supervisor.sv
module sync_supervisor
  import sync_sup_pkg::*;
#(
  parameter int AGE_W      = 16,
  parameter int AGE_STEP   = 4,
  parameter int AGE_LIMIT  = 21600,
  parameter int PPS_W      = 8,
  parameter int PPS_STEP   = 4,
  parameter int PPS_RELOAD = 120,
  parameter int OFS_W      = 32,
  parameter int FOLD_AT    = 500,
  parameter int FOLD_SPAN  = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adj_tick,
  input  logic                    pps_pulse,
  input  logic signed [OFS_W-1:0] pps_offset,
  input  logic                    sync_upd,
  input  logic [1:0]              sync_leap,
  output logic [1:0]              leap_o,
  output logic                    pps_valid_o,
  output logic signed [OFS_W-1:0] pps_adj_o
);
  leap_e leap_q;

  age_watchdog #(
    .AGE_W    (AGE_W),
    .AGE_STEP (AGE_STEP),
    .AGE_LIMIT(AGE_LIMIT)
  ) u_age (
    .clk      (clk),
    .rst      (rst),
    .tick     (adj_tick),
    .sync_upd (sync_upd),
    .sync_leap(leap_e'(sync_leap)),
    .leap_q   (leap_q)
  );

  pps_presence #(
    .CNT_W     (PPS_W),
    .PPS_STEP  (PPS_STEP),
    .PPS_RELOAD(PPS_RELOAD)
  ) u_presence (
    .clk    (clk),
    .rst    (rst),
    .tick   (adj_tick),
    .pulse  (pps_pulse),
    .valid_q(pps_valid_o)
  );

  offset_folder #(
    .OFS_W    (OFS_W),
    .FOLD_AT  (FOLD_AT),
    .FOLD_SPAN(FOLD_SPAN)
  ) u_fold (
    .clk   (clk),
    .rst   (rst),
    .load  (pps_pulse),
    .ofs_in(pps_offset),
    .adj_q (pps_adj_o)
  );

  assign leap_o = leap_q;
endmodule

// File: rtl/sync_supervisor_chk.sv
module sync_supervisor_chk #(
  parameter int OFS_W     = 32,
  parameter int FOLD_AT   = 500,
  parameter int FOLD_SPAN = 1000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    adj_tick,
  input logic                    pps_pulse,
  input logic signed [OFS_W-1:0] pps_offset,
  input logic                    sync_upd,
  input logic [1:0]              sync_leap,
  input logic [1:0]              leap_o,
  input logic                    pps_valid_o,
  input logic signed [OFS_W-1:0] pps_adj_o
);
  localparam logic signed [OFS_W-1:0] AT_V   = OFS_W'(FOLD_AT);
  localparam logic signed [OFS_W-1:0] SPAN_V = OFS_W'(FOLD_SPAN);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (leap_o == 2'b11 && !pps_valid_o && pps_adj_o == '0)); // R1

  AST_PULSE_ARMS: assert property (@(posedge clk) disable iff (rst)
    pps_pulse |=> pps_valid_o); // R2

  AST_FOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pps_pulse && pps_offset >= AT_V) |=> (pps_adj_o == $past(pps_offset) - SPAN_V)); // R3

  AST_FOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (pps_pulse && pps_offset < AT_V) |=> (pps_adj_o == $past(pps_offset))); // R3

  AST_VALID_DROP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(pps_valid_o) |-> $past(adj_tick)); // R4

  AST_UPDATE_LOADS_LEAP: assert property (@(posedge clk) disable iff (rst)
    sync_upd |=> (leap_o == $past(sync_leap))); // R7

  AST_ADJ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pps_pulse |=> $stable(pps_adj_o)); // R9
endmodule

bind sync_supervisor sync_supervisor_chk #(
  .OFS_W    (OFS_W),
  .FOLD_AT  (FOLD_AT),
  .FOLD_SPAN(FOLD_SPAN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adj_tick   (adj_tick),
  .pps_pulse  (pps_pulse),
  .pps_offset (pps_offset),
  .sync_upd   (sync_upd),
  .sync_leap  (sync_leap),
  .leap_o     (leap_o),
  .pps_valid_o(pps_valid_o),
  .pps_adj_o  (pps_adj_o)
);

// File: tb/sync_supervisor_test.sv
`timescale 1ns/1ps
module sync_supervisor_test;
  localparam int OFS_W = 32;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    adj_tick = 1'b0;
  logic                    pps_pulse = 1'b0;
  logic signed [OFS_W-1:0] pps_offset = '0;
  logic                    sync_upd = 1'b0;
  logic [1:0]              sync_leap = 2'b00;
  logic [1:0]              leap_o;
  logic                    pps_valid_o;
  logic signed [OFS_W-1:0] pps_adj_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_supervisor #(
    .AGE_STEP  (4),
    .AGE_LIMIT (42),
    .PPS_STEP  (4),
    .PPS_RELOAD(10)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .adj_tick   (adj_tick),
    .pps_pulse  (pps_pulse),
    .pps_offset (pps_offset),
    .sync_upd   (sync_upd),
    .sync_leap  (sync_leap),
    .leap_o     (leap_o),
    .pps_valid_o(pps_valid_o),
    .pps_adj_o  (pps_adj_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply inputs for one cycle; returns at the next falling edge with outputs settled
  task automatic step(input bit tk, input bit pp, input int ofs, input bit su, input bit [1:0] lp);
    adj_tick   = tk;
    pps_pulse  = pp;
    pps_offset = ofs;
    sync_upd   = su;
    sync_leap  = lp;
    @(negedge clk);
    adj_tick  = 1'b0;
    pps_pulse = 1'b0;
    sync_upd  = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 leap", int'(leap_o), 3);
    chk("R1 valid", int'(pps_valid_o), 0);
    chk("R1 adj", int'(pps_adj_o), 0);
  endtask

  task automatic t_fold();
    int ofs[7] = '{0, 499, 500, 999, 1000, -300, -500};
    int exp[7] = '{0, 499, -500, -1, 0, -300, -500};
    foreach (ofs[i]) begin
      step(1'b0, 1'b1, ofs[i], 1'b0, 2'b00);
      chk("R3 fold", int'(pps_adj_o), exp[i]);
    end
    chk("R2 valid after pulse", int'(pps_valid_o), 1);
    step(1'b0, 1'b1, 777, 1'b0, 2'b00);
    chk("R2 adj loaded", int'(pps_adj_o), -223);
  endtask

  task automatic t_hold();
    step(1'b0, 1'b1, 123, 1'b0, 2'b00);
    for (int i = 0; i < 5; i++) step(i[0], 1'b0, 600 + i, 1'b0, 2'b00);
    chk("R9 adj held", int'(pps_adj_o), 123);
  endtask

  task automatic t_decay();
    step(1'b0, 1'b1, 7, 1'b0, 2'b00);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R4 valid at 6", int'(pps_valid_o), 1);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R4 valid at 2", int'(pps_valid_o), 1);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R4 valid below zero", int'(pps_valid_o), 0);
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 0, 1'b0, 2'b00);
      chk("R5 no decay when not positive", int'(pps_valid_o), 0);
    end
  endtask

  task automatic t_collide();
    step(1'b1, 1'b1, 0, 1'b0, 2'b00);
    chk("R8 pulse with strobe", int'(pps_valid_o), 1);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R8 reload not decremented", int'(pps_valid_o), 1);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R8 drops after third strobe", int'(pps_valid_o), 0);
  endtask

  task automatic t_watchdog();
    step(1'b0, 1'b0, 0, 1'b1, 2'b00);
    chk("R7 leap loaded", int'(leap_o), 0);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R6 leap before limit", int'(leap_o), 0);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R6 clamp forces unsync", int'(leap_o), 3);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R6 stays unsync", int'(leap_o), 3);
    step(1'b1, 1'b0, 0, 1'b1, 2'b01);
    chk("R7 update with strobe", int'(leap_o), 1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R7 age cleared despite strobe", int'(leap_o), 1);
    step(1'b1, 1'b0, 0, 1'b0, 2'b00);
    chk("R6 limit after update", int'(leap_o), 3);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fold();
    t_hold();
    t_decay();
    t_collide();
    t_watchdog();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule